// File: doc/BRIEF.md
# Debug Data-Bus Scan Chain

This block is a serial scan chain wrapped around a processor core's 32-bit data bus, extended by one breakpoint flag bit. A debugger drives it through a test access port controller: a capture loads the chain with the word the core most recently drove onto its bus, a run of shifts moves that word out on the serial output while a new word moves in, and an update hands the new word to the core as an injected instruction or data word, together with a breakpoint bit.

The chain only responds while an internal-test instruction is in effect and the chain select value equals this chain's number. Otherwise it ignores capture, shift and update, keeps its contents, and holds its serial output low. Reading a core register uses a two-cycle store: the address appears in the first core cycle with the core not driving, and the register value is driven in the second. The bus snooper keeps only the values of cycles in which the core drives the bus, so a capture taken after the store returns the register value. The update is carried from the test clock into the core clock domain and appears there as a one-cycle valid strobe.

Top module: `dbg_bus_chain`

## Requirements
- R1: The chain is 33 bits long. Bit 0 is the breakpoint flag and bits 32:1 carry data bits 0 to 31. Bits leave on `tdo` and enter from `tdi` lowest bit first: the bit seen on `tdo` after a capture is bit 0, and the k-th `tdi` bit shifted (counting from 0) ends in bit k after 33 shifts.
- R2: The chain is active only while `intest_en` is 1 and `chain_sel` equals 1 (4-bit select).
- R3: While inactive, capture, shift and update have no effect: the chain contents are held, `tdo` is 0, and no injection strobe is produced.
- R4: A capture while active loads bits 32:1 with the `core_bus` value of the most recent core clock cycle in which `core_bus_drive` was 1; cycles with `core_bus_drive` at 0 (such as the address cycle of a store) are ignored.
- R5: A capture while active loads bit 0 with the breakpoint flag currently presented on `breakpoint_out`.
- R6: An update while active produces exactly one core-clock cycle with `inject_valid` at 1, in which `inject_data` equals chain bits 32:1 and `breakpoint_out` equals chain bit 0; both hold their values until the next update.
- R7: `tdo` changes only on the falling edge of `tck`.
- R8: After reset `tdo`, `inject_valid`, `inject_data`, `breakpoint_out` and the chain are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| core_clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| tap_capture | input | 1 | Capture strobe from the TAP controller |
| tap_shift | input | 1 | Shift strobe from the TAP controller |
| tap_update | input | 1 | Update strobe from the TAP controller |
| tdi | input | 1 | Serial data in |
| chain_sel | input | 4 | Selected chain number |
| intest_en | input | 1 | Internal-test instruction is active |
| core_bus | input | 32 | Core data-bus value |
| core_bus_drive | input | 1 | 1 when the core drives the data bus |
| tdo | output | 1 | Serial data out, falling-edge timed |
| inject_data | output | 32 | Word presented to the core |
| inject_valid | output | 1 | One-cycle strobe in the core domain per update |
| breakpoint_out | output | 1 | Breakpoint flag presented to the core |

## Verification
The bench reads a register value through a two-cycle store pattern, so a design that snooped the bus on every cycle would return the address instead of the value. It exercises the chain with internal test off and with a wrong chain number, then reselects and shifts out without capturing: a design that captured, shifted or updated while deselected would show a non-zero `tdo`, a stray injection strobe or altered contents. A scoreboard matches every injection against the word and flag shifted in, catching reversed bit order, a strobe longer than one core cycle, or a missing flag readback on capture.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int DEF_DATA_W   = 32;
  localparam int DEF_SEL_W    = 4;
  localparam int DEF_CHAIN_ID = 1;
  localparam int DEF_SYNC_STG = 2;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } tap_strobe_t;
endpackage

// File: rtl/dbs_bus_snoop.sv
module dbs_bus_snoop #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus,
  input  logic              drive,
  output logic [DATA_W-1:0] snap
);
  always_ff @(posedge clk) begin
    if (rst)        snap <= '0;
    else if (drive) snap <= bus;
  end

  // R4: cycles without the core driving leave the snapshot alone
  p_snap_ignores_undriven_r4: assert property (@(posedge clk) disable iff (rst)
    !drive |=> $stable(snap));
endmodule

// File: rtl/dbs_toggle_sync.sv
module dbs_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-1:0], tog_in};
  end

  assign pulse = stg[STAGES] ^ stg[STAGES-1];
endmodule

// File: rtl/dbs_chain_reg.sv
module dbs_chain_reg
  import dbs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SEL_W    = 4,
  parameter int CHAIN_ID = 1,
  localparam int LEN     = DATA_W + 1
) (
  input  logic              tck,
  input  logic              rst,
  input  tap_strobe_t       strobe,
  input  logic              tdi,
  input  logic [SEL_W-1:0]  chain_sel,
  input  logic              intest_en,
  input  logic [DATA_W-1:0] cap_data,
  output logic              tdo,
  output logic [LEN-1:0]    upd_word,
  output logic              upd_toggle
);
  logic [LEN-1:0] sr;
  logic           active;

  assign active = intest_en && (chain_sel == SEL_W'(CHAIN_ID));

  always_ff @(posedge tck) begin
    if (rst) begin
      sr         <= '0;
      upd_word   <= '0;
      upd_toggle <= 1'b0;
    end else if (active) begin
      if (strobe.capture)
        sr <= {cap_data, upd_word[0]};
      else if (strobe.shift)
        sr <= {tdi, sr[LEN-1:1]};
      if (strobe.update) begin
        upd_word   <= sr;
        upd_toggle <= ~upd_toggle;
      end
    end
  end

  always_ff @(negedge tck) begin
    if (rst)         tdo <= 1'b0;
    else if (active) tdo <= sr[0];
    else             tdo <= 1'b0;
  end

  // R3: a deselected chain keeps its contents
  p_held_inactive_r3: assert property (@(posedge tck) disable iff (rst)
    !active |=> $stable(sr));
  // R3: a deselected chain raises no update
  p_no_update_inactive_r3: assert property (@(posedge tck) disable iff (rst)
    !active |=> $stable(upd_toggle));
  // R6: an active update hands a new word across
  p_update_toggles_r6: assert property (@(posedge tck) disable iff (rst)
    (active && strobe.update) |=> (upd_toggle != $past(upd_toggle)));
endmodule

// File: rtl/dbg_bus_chain.sv
module dbg_bus_chain
  import dbs_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int SEL_W    = DEF_SEL_W,
  parameter int CHAIN_ID = DEF_CHAIN_ID,
  parameter int SYNC_STG = DEF_SYNC_STG
) (
  input  logic              tck,
  input  logic              core_clk,
  input  logic              rst,
  input  logic              tap_capture,
  input  logic              tap_shift,
  input  logic              tap_update,
  input  logic              tdi,
  input  logic [SEL_W-1:0]  chain_sel,
  input  logic              intest_en,
  input  logic [DATA_W-1:0] core_bus,
  input  logic              core_bus_drive,
  output logic              tdo,
  output logic [DATA_W-1:0] inject_data,
  output logic              inject_valid,
  output logic              breakpoint_out
);
  localparam int LEN = DATA_W + 1;

  tap_strobe_t       strobe;
  logic [DATA_W-1:0] snap;
  logic [LEN-1:0]    upd_word;
  logic              upd_toggle;
  logic              upd_pulse;

  assign strobe = '{capture: tap_capture, shift: tap_shift, update: tap_update};

  dbs_bus_snoop #(.DATA_W(DATA_W)) u_snoop (
    .clk(core_clk), .rst(rst), .bus(core_bus), .drive(core_bus_drive), .snap(snap)
  );

  dbs_chain_reg #(.DATA_W(DATA_W), .SEL_W(SEL_W), .CHAIN_ID(CHAIN_ID)) u_chain (
    .tck(tck), .rst(rst), .strobe(strobe), .tdi(tdi), .chain_sel(chain_sel),
    .intest_en(intest_en), .cap_data(snap), .tdo(tdo),
    .upd_word(upd_word), .upd_toggle(upd_toggle)
  );

  dbs_toggle_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(core_clk), .rst(rst), .tog_in(upd_toggle), .pulse(upd_pulse)
  );

  always_ff @(posedge core_clk) begin
    if (rst) begin
      inject_data    <= '0;
      breakpoint_out <= 1'b0;
      inject_valid   <= 1'b0;
    end else begin
      inject_valid <= upd_pulse;
      if (upd_pulse) begin
        inject_data    <= upd_word[LEN-1:1];
        breakpoint_out <= upd_word[0];
      end
    end
  end

  // R6: the strobe lasts a single core cycle
  p_pulse_single_r6: assert property (@(posedge core_clk) disable iff (rst)
    inject_valid |=> !inject_valid);
  // R6: the presented word only moves together with the strobe
  p_data_with_valid_r6: assert property (@(posedge core_clk) disable iff (rst)
    ((inject_data != $past(inject_data)) || (breakpoint_out != $past(breakpoint_out)))
      |-> inject_valid);
endmodule

// File: tb/test_dbg_bus_chain.sv
module test_dbg_bus_chain;
  localparam int LEN = 33;

  logic tck = 1'b0, core_clk = 1'b0, rst = 1'b1;
  logic tap_capture = 0, tap_shift = 0, tap_update = 0, tdi = 0;
  logic [3:0] chain_sel = 4'd0;
  logic intest_en = 0;
  logic [31:0] core_bus = '0;
  logic core_bus_drive = 0;
  logic tdo, inject_valid, breakpoint_out;
  logic [31:0] inject_data;

  int checks = 0, errors = 0, pulses = 0, pushes = 0;
  bit done = 0;
  logic [LEN-1:0] exp_q[$];

  always #4  core_clk = ~core_clk;
  always #21 tck = ~tck;

  dbg_bus_chain i_dbg_bus_chain (
    .tck(tck), .core_clk(core_clk), .rst(rst), .tap_capture(tap_capture),
    .tap_shift(tap_shift), .tap_update(tap_update), .tdi(tdi), .chain_sel(chain_sel),
    .intest_en(intest_en), .core_bus(core_bus), .core_bus_drive(core_bus_drive),
    .tdo(tdo), .inject_data(inject_data), .inject_valid(inject_valid),
    .breakpoint_out(breakpoint_out)
  );

  task automatic chk(input bit ok, input string req, input logic [LEN-1:0] act,
                     input logic [LEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tck_step();
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic core_cycle(input logic [31:0] v, input logic drv);
    @(negedge core_clk); core_bus = v; core_bus_drive = drv;
    @(negedge core_clk); core_bus_drive = 1'b0;
  endtask

  // capture (optional), 33 shifts LSB first, update (optional)
  task automatic scan(input bit do_cap, input logic [LEN-1:0] din, input bit do_upd,
                      input bit expect_inject, output logic [LEN-1:0] dout);
    if (do_cap) begin tap_capture = 1; tck_step(); tap_capture = 0; end
    for (int i = 0; i < LEN; i++) begin
      dout[i] = tdo;
      tap_shift = 1; tdi = din[i];
      tck_step();
    end
    tap_shift = 0; tdi = 0;
    if (do_upd) begin
      if (expect_inject) begin exp_q.push_back(din); pushes++; end
      tap_update = 1; tck_step(); tap_update = 0;
    end
    repeat (3) tck_step();
  endtask

  // scoreboard monitor
  logic prev_valid = 0;
  always @(negedge core_clk) begin
    if (!rst) begin
      if (inject_valid) begin
        pulses++;
        if (prev_valid) chk(0, "R6 strobe longer than one cycle", 1, 0);
        if (exp_q.size() == 0) chk(0, "R3 unexpected injection", {inject_data, breakpoint_out}, '0);
        else begin
          logic [LEN-1:0] e;
          e = exp_q.pop_front();
          chk({inject_data, breakpoint_out} == e, "R6 injected word/flag",
              {inject_data, breakpoint_out}, e);
        end
      end
      prev_valid = inject_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge core_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [LEN-1:0] got;
    logic [LEN-1:0] snapshot_t;
    bit tdo_edge_ok;
    repeat (6) tck_step();
    rst = 0;
    tck_step();
    // R8 reset state
    chk(tdo == 0 && inject_valid == 0, "R8 reset tdo/valid", {tdo, inject_valid}, '0);
    chk(inject_data == 0 && breakpoint_out == 0, "R8 reset data/flag",
        {inject_data, breakpoint_out}, '0);

    // R4 plain driven value, then undriven cycle with other bus value
    core_cycle(32'hA5A5_0F0F, 1'b1);
    core_cycle(32'h0000_1234, 1'b0);
    chain_sel = 4'd1; intest_en = 1;
    scan(1, {32'hCAFE_BABE, 1'b1}, 1, 1, got);
    chk(got[32:1] == 32'hA5A5_0F0F, "R4 captured driven bus", got, {32'hA5A5_0F0F, 1'b0});
    chk(got[0] == 1'b0, "R5 captured flag readback 0", got, {32'hA5A5_0F0F, 1'b0});
    chk(inject_data == 32'hCAFE_BABE && breakpoint_out == 1, "R6 word held after update",
        {inject_data, breakpoint_out}, {32'hCAFE_BABE, 1'b1});

    // R4 two-cycle store: address cycle undriven, value cycle driven
    core_cycle(32'h0000_0100, 1'b0);
    core_cycle(32'h1357_9BDF, 1'b1);
    core_cycle(32'hFFFF_0000, 1'b0);
    scan(1, {32'h0F0F_F0F0, 1'b0}, 1, 1, got);
    chk(got == {32'h1357_9BDF, 1'b1}, "R4/R5 store value and flag 1 (R1 order)", got,
        {32'h1357_9BDF, 1'b1});
    chk(breakpoint_out == 0 && inject_data == 32'h0F0F_F0F0, "R6 second word",
        {inject_data, breakpoint_out}, {32'h0F0F_F0F0, 1'b0});

    // R2/R3 internal test off
    core_cycle(32'h5555_AAAA, 1'b1);
    intest_en = 0;
    scan(1, {32'hDEAD_BEEF, 1'b1}, 1, 0, got);
    chk(got == '0, "R3 tdo low with intest off", got, '0);
    chk(breakpoint_out == 0 && inject_data == 32'h0F0F_F0F0, "R3 no inject with intest off",
        {inject_data, breakpoint_out}, {32'h0F0F_F0F0, 1'b0});

    // R2/R3 wrong chain number
    intest_en = 1; chain_sel = 4'd2;
    scan(1, {32'h1111_2222, 1'b1}, 1, 0, got);
    chk(got == '0, "R3 tdo low with chain 2", got, '0);
    chk(inject_data == 32'h0F0F_F0F0, "R3 no inject with chain 2",
        {inject_data, breakpoint_out}, {32'h0F0F_F0F0, 1'b0});

    // R3 contents held: reselect and shift out without capture
    chain_sel = 4'd1;
    scan(0, {32'h8000_0001, 1'b1}, 1, 1, got);
    chk(got == {32'h0F0F_F0F0, 1'b0}, "R3 contents held while deselected", got,
        {32'h0F0F_F0F0, 1'b0});

    // R1 bit order: chain now holds the word shifted in; shift it back out
    snapshot_t = {32'h8000_0001, 1'b1};
    scan(0, '0, 0, 0, got);
    chk(got == snapshot_t, "R1 shifted word returns in order", got, snapshot_t);

    // R7: tdo stays put across a rising edge, moves after the falling edge
    scan(0, {32'h0, 1'b1}, 0, 0, got);  // chain bit0 = 1 now
    tdo_edge_ok = (tdo == 1'b1);
    tap_shift = 1; tdi = 0;
    @(posedge tck); #1;
    tdo_edge_ok = tdo_edge_ok && (tdo == 1'b1);
    @(negedge tck); #1;
    tap_shift = 0;
    chk(tdo_edge_ok && tdo == 1'b0, "R7 tdo moves on falling edge", {32'h0, tdo}, '0);

    repeat (4) tck_step();
    chk(exp_q.size() == 0 && pulses == pushes, "R6 one strobe per update",
        LEN'(pulses), LEN'(pushes));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule